// File: doc/BRIEF.md
# External SRAM Wait-State Sequencer

This block paces every external static-RAM access of a bus interface. A 24-bit control word holds one wait-state count for each of three address areas: area 2, area 3, and a default area for addresses that no area decoder claims. The word also holds two force bits for the bus-request and bus-lock lines. When an access is accepted, the sequencer drives a strobe for the programmed number of wait states. It raises a one-cycle ready pulse in the last of those cycles. It then holds the bus for zero, one or two trailing cycles. These cycles lengthen data hold and release time but do not delay completion.

The access request comes with a two-bit area select and a read-modify-write flag. A request is taken only while the unit owns the bus and the previous access, trailing cycles included, has fully ended. Bus request and bus lock come from the force bits and from the access activity. A read-only bit of the control word reflects bus ownership.

Top module: `sram_wait_seq`

## Requirements
- R1: After reset the control word reads 0x1FFC00: the default-area count (bits 20:16) is 31, the area-3 count (bits 15:13) and the area-2 count (bits 12:10) are 7, and the request force (bit 23) and lock force (bit 22) are 0.
- R2: Bits 9:0 always read 0 and ignore writes. Bit 21 ignores writes and reads `bus_grant` as sampled at the previous clock edge.
- R3: An accepted access keeps `mem_stb` high for exactly N cycles. N is taken from the field chosen by `acc_area`: 2 selects area 2, 3 selects area 3, and 0 or 1 selects the default area.
- R4: A count field programmed to 0 gives a one-cycle access.
- R5: After the strobe phase, `mem_hold` is high, with `mem_stb` low, for 0 cycles when N is 1 to 3, for 1 cycle when N is 4 to 7, and for 2 cycles when N is 8 or more.
- R6: `acc_rdy` pulses exactly once per access, in the last cycle that `mem_stb` is high.
- R7: A request is accepted only when the unit is idle and bus bit 21 is 1. With `acc_req` held high, a new strobe phase starts one idle cycle after the trailing cycles end, so accesses repeat every N+T+1 cycles.
- R8: `bus_req` equals the request force bit OR `acc_req` OR `acc_busy`.
- R9: `bus_lock` equals the lock force bit OR (`acc_busy` AND the accepted access had `acc_rmw` set).
- R10: When a control-word write and an access acceptance fall on the same clock edge, that access uses the counts from before the write. Later accesses use the new counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control-word write enable |
| cfg_wdata | input | 24 | Control-word write data |
| cfg_rdata | output | 24 | Control-word read data |
| bus_grant | input | 1 | Bus ownership granted to this unit |
| acc_req | input | 1 | Access request |
| acc_area | input | 2 | Area select: 2 = area 2, 3 = area 3, else default |
| acc_rmw | input | 1 | Request is a read-modify-write |
| acc_busy | output | 1 | Strobe or trailing phase in progress |
| acc_rdy | output | 1 | Access complete; read data valid |
| mem_stb | output | 1 | Memory strobe (wait-state phase) |
| mem_hold | output | 1 | Trailing hold phase |
| bus_req | output | 1 | Bus request |
| bus_lock | output | 1 | Bus lock |

## Verification
A control-word write and the acceptance of an access can fall on the same clock edge. In that case the new count must not leak into the access that is just starting. The bench provokes this by driving `cfg_we` together with `acc_req`, using two different area-2 counts. It first judges the strobe length and trailing count against the old value. It then runs a second access and judges it against the new value. The force bits and the access activity also meet on `bus_req` and `bus_lock`. All hold-bit and access-type pairings are checked while an access is in flight.

// File: rtl/sram_ws_pkg.sv
package sram_ws_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_TRAIL = 2'd2
   } ws_state_t;

   localparam logic [1:0] AREA_DEF_A = 2'd0;
   localparam logic [1:0] AREA_DEF_B = 2'd1;
   localparam logic [1:0] AREA_TWO   = 2'd2;
   localparam logic [1:0] AREA_THREE = 2'd3;

   localparam int TRAIL_W = 2;

endpackage

// File: rtl/sram_ws_cfg.sv
module sram_ws_cfg #(
   parameter int REG_W   = 24,
   parameter int AREA_W  = 3,
   parameter int DEF_W   = 5,
   parameter int A2_LSB  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_W-1:0]  wdata,
   input  logic              own,
   output logic [REG_W-1:0]  rdata,
   output logic              force_req,
   output logic              force_lock,
   output logic [DEF_W-1:0]  def_cnt,
   output logic [AREA_W-1:0] a2_cnt,
   output logic [AREA_W-1:0] a3_cnt
);
   localparam int A3_LSB   = A2_LSB + AREA_W;
   localparam int DEF_LSB  = A3_LSB + AREA_W;
   localparam int OWN_BIT  = DEF_LSB + DEF_W;
   localparam int LOCK_BIT = OWN_BIT + 1;
   localparam int REQ_BIT  = OWN_BIT + 2;

   generate
      if (REQ_BIT != REG_W - 1) begin : g_bad_layout
         $error("sram_ws_cfg: field layout does not fill the word");
      end
      if (A2_LSB < 1) begin : g_bad_lsb
         $error("sram_ws_cfg: reserved low bits required");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         force_req  <= 1'b0;
         force_lock <= 1'b0;
         def_cnt    <= '1;
         a2_cnt     <= '1;
         a3_cnt     <= '1;
      end else if (we) begin
         force_req  <= wdata[REQ_BIT];
         force_lock <= wdata[LOCK_BIT];
         def_cnt    <= wdata[DEF_LSB +: DEF_W];
         a3_cnt     <= wdata[A3_LSB +: AREA_W];
         a2_cnt     <= wdata[A2_LSB +: AREA_W];
      end
   end

   logic unused_wbits;
   assign unused_wbits = ^{wdata[OWN_BIT], wdata[A2_LSB-1:0]};

   always_comb begin
      rdata                       = '0;
      rdata[REQ_BIT]              = force_req;
      rdata[LOCK_BIT]             = force_lock;
      rdata[OWN_BIT]              = own;
      rdata[DEF_LSB +: DEF_W]     = def_cnt;
      rdata[A3_LSB +: AREA_W]     = a3_cnt;
      rdata[A2_LSB +: AREA_W]     = a2_cnt;
   end
endmodule

// File: rtl/sram_ws_select.sv
module sram_ws_select
   import sram_ws_pkg::*;
#(
   parameter int AREA_W   = 3,
   parameter int DEF_W    = 5,
   parameter bit TRAIL_EN = 1'b1
) (
   input  logic [1:0]         area,
   input  logic [DEF_W-1:0]   def_cnt,
   input  logic [AREA_W-1:0]  a2_cnt,
   input  logic [AREA_W-1:0]  a3_cnt,
   output logic [DEF_W-1:0]   eff_cnt,
   output logic [TRAIL_W-1:0] trail_cnt
);
   generate
      if (AREA_W > DEF_W) begin : g_bad_width
         $error("sram_ws_select: area field wider than default field");
      end
   endgenerate

   logic [DEF_W-1:0] raw_cnt;

   always_comb begin
      unique case (area)
         AREA_TWO:   raw_cnt = DEF_W'(a2_cnt);
         AREA_THREE: raw_cnt = DEF_W'(a3_cnt);
         default:    raw_cnt = def_cnt;
      endcase
      eff_cnt = (raw_cnt == '0) ? DEF_W'(1) : raw_cnt;
   end

   generate
      if (TRAIL_EN) begin : g_trail
         always_comb begin
            if (int'(eff_cnt) >= 8)      trail_cnt = TRAIL_W'(2);
            else if (int'(eff_cnt) >= 4) trail_cnt = TRAIL_W'(1);
            else                         trail_cnt = '0;
         end
      end else begin : g_no_trail
         assign trail_cnt = '0;
      end
   endgenerate
endmodule

// File: rtl/sram_ws_timer.sv
module sram_ws_timer
   import sram_ws_pkg::*;
#(
   parameter int DEF_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic               own,
   input  logic [DEF_W-1:0]   eff_cnt,
   input  logic [TRAIL_W-1:0] trail_cnt,
   output logic               accept,
   output logic               busy,
   output logic               stb,
   output logic               hold,
   output logic               rdy
);
   ws_state_t          state;
   logic [DEF_W-1:0]   wait_left;
   logic [TRAIL_W-1:0] trail_left;
   logic [TRAIL_W-1:0] trail_plan;

   assign accept = (state == ST_IDLE) && req && own;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         wait_left  <= '0;
         trail_left <= '0;
         trail_plan <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  state      <= ST_WAIT;
                  wait_left  <= eff_cnt;
                  trail_plan <= trail_cnt;
               end
            end
            ST_WAIT: begin
               if (wait_left == DEF_W'(1)) begin
                  if (trail_plan != '0) begin
                     state      <= ST_TRAIL;
                     trail_left <= trail_plan;
                  end else begin
                     state <= ST_IDLE;
                  end
               end else begin
                  wait_left <= wait_left - DEF_W'(1);
               end
            end
            ST_TRAIL: begin
               if (trail_left == TRAIL_W'(1)) state <= ST_IDLE;
               else trail_left <= trail_left - TRAIL_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
   assign stb  = (state == ST_WAIT);
   assign hold = (state == ST_TRAIL);
   assign rdy  = (state == ST_WAIT) && (wait_left == DEF_W'(1));
endmodule

// File: rtl/sram_ws_busctl.sv
module sram_ws_busctl (
   input  logic clk,
   input  logic rst_n,
   input  logic grant,
   input  logic accept,
   input  logic rmw,
   input  logic req,
   input  logic busy,
   input  logic force_req,
   input  logic force_lock,
   output logic own,
   output logic bus_req,
   output logic bus_lock
);
   logic rmw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own   <= 1'b0;
         rmw_q <= 1'b0;
      end else begin
         own <= grant;
         if (accept) rmw_q <= rmw;
      end
   end

   assign bus_req  = force_req  | req | busy;
   assign bus_lock = force_lock | (busy & rmw_q);
endmodule

// File: rtl/sram_wait_seq.sv
module sram_wait_seq
   import sram_ws_pkg::*;
#(
   parameter int REG_W    = 24,
   parameter int AREA_W   = 3,
   parameter int DEF_W    = 5,
   parameter int A2_LSB   = 10,
   parameter bit TRAIL_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic             bus_grant,
   input  logic             acc_req,
   input  logic [1:0]       acc_area,
   input  logic             acc_rmw,
   output logic             acc_busy,
   output logic             acc_rdy,
   output logic             mem_stb,
   output logic             mem_hold,
   output logic             bus_req,
   output logic             bus_lock
);
   localparam int OWN_BIT  = A2_LSB + 2*AREA_W + DEF_W;
   localparam int LOCK_BIT = OWN_BIT + 1;
   localparam int REQ_BIT  = OWN_BIT + 2;

   logic               own;
   logic               force_req;
   logic               force_lock;
   logic [DEF_W-1:0]   def_cnt;
   logic [AREA_W-1:0]  a2_cnt;
   logic [AREA_W-1:0]  a3_cnt;
   logic [DEF_W-1:0]   eff_cnt;
   logic [TRAIL_W-1:0] trail_cnt;
   logic               accept;

   sram_ws_cfg #(.REG_W(REG_W), .AREA_W(AREA_W), .DEF_W(DEF_W), .A2_LSB(A2_LSB)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .own(own),
      .rdata(cfg_rdata), .force_req(force_req), .force_lock(force_lock),
      .def_cnt(def_cnt), .a2_cnt(a2_cnt), .a3_cnt(a3_cnt)
   );

   sram_ws_select #(.AREA_W(AREA_W), .DEF_W(DEF_W), .TRAIL_EN(TRAIL_EN)) u_sel (
      .area(acc_area), .def_cnt(def_cnt), .a2_cnt(a2_cnt), .a3_cnt(a3_cnt),
      .eff_cnt(eff_cnt), .trail_cnt(trail_cnt)
   );

   sram_ws_timer #(.DEF_W(DEF_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .req(acc_req), .own(own),
      .eff_cnt(eff_cnt), .trail_cnt(trail_cnt), .accept(accept),
      .busy(acc_busy), .stb(mem_stb), .hold(mem_hold), .rdy(acc_rdy)
   );

   sram_ws_busctl u_bus (
      .clk(clk), .rst_n(rst_n), .grant(bus_grant), .accept(accept),
      .rmw(acc_rmw), .req(acc_req), .busy(acc_busy),
      .force_req(force_req), .force_lock(force_lock),
      .own(own), .bus_req(bus_req), .bus_lock(bus_lock)
   );
endmodule

// File: rtl/sram_ws_chk.sv
module sram_ws_chk #(
   parameter int REG_W    = 24,
   parameter int REQ_BIT  = 23,
   parameter int LOCK_BIT = 22
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] cfg_rdata,
   input logic             acc_req,
   input logic             acc_busy,
   input logic             acc_rdy,
   input logic             mem_stb,
   input logic             mem_hold,
   input logic             bus_req,
   input logic             bus_lock
);
   assert_rdy_in_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rdy |-> mem_stb);

   assert_strobe_ends_after_rdy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rdy |=> !mem_stb);

   assert_hold_excludes_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_stb && mem_hold));

   assert_start_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_stb) |-> !$past(acc_busy));

   assert_req_while_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req || acc_busy || cfg_rdata[REQ_BIT]) |-> bus_req);

   assert_lock_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[LOCK_BIT] |-> bus_lock);

   assert_lock_only_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_busy && !cfg_rdata[LOCK_BIT]) |-> !bus_lock);
endmodule

bind sram_wait_seq sram_ws_chk #(.REG_W(REG_W), .REQ_BIT(REQ_BIT), .LOCK_BIT(LOCK_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .acc_req(acc_req),
   .acc_busy(acc_busy), .acc_rdy(acc_rdy), .mem_stb(mem_stb), .mem_hold(mem_hold),
   .bus_req(bus_req), .bus_lock(bus_lock)
);

// File: tb/test_sram_wait_seq.sv
`timescale 1ns/1ps
module test_sram_wait_seq;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [23:0] cfg_wdata;
   logic [23:0] cfg_rdata;
   logic        bus_grant;
   logic        acc_req;
   logic [1:0]  acc_area;
   logic        acc_rmw;
   logic        acc_busy, acc_rdy, mem_stb, mem_hold, bus_req, bus_lock;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   sram_wait_seq i_sram_wait_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .bus_grant(bus_grant), .acc_req(acc_req),
      .acc_area(acc_area), .acc_rmw(acc_rmw), .acc_busy(acc_busy),
      .acc_rdy(acc_rdy), .mem_stb(mem_stb), .mem_hold(mem_hold),
      .bus_req(bus_req), .bus_lock(bus_lock)
   );

   // {area[1:0], programmed count[4:0], expected strobe cycles[4:0], expected trailing[1:0]}
   localparam logic [13:0] VEC [11] = '{
      {2'd0, 5'd1,  5'd1,  2'd0},
      {2'd0, 5'd3,  5'd3,  2'd0},
      {2'd0, 5'd4,  5'd4,  2'd1},
      {2'd0, 5'd7,  5'd7,  2'd1},
      {2'd0, 5'd8,  5'd8,  2'd2},
      {2'd0, 5'd31, 5'd31, 2'd2},
      {2'd2, 5'd4,  5'd4,  2'd1},
      {2'd3, 5'd7,  5'd7,  2'd1},
      {2'd2, 5'd0,  5'd1,  2'd0},
      {2'd3, 5'd3,  5'd3,  2'd0},
      {2'd1, 5'd8,  5'd8,  2'd2}
   };

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] word(input bit fr, input bit fl, input logic [4:0] d,
                                        input logic [2:0] a3, input logic [2:0] a2);
      return {fr, fl, 1'b0, d, a3, a2, 10'd0};
   endfunction

   task automatic wr(input logic [23:0] w);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic run_acc(input logic [1:0] ar, input bit rmw,
                          output int ns, output int nh, output int rat, output int rc);
      ns = 0; nh = 0; rat = -1; rc = 0;
      @(negedge clk); acc_req = 1'b1; acc_area = ar; acc_rmw = rmw;
      @(negedge clk); acc_req = 1'b0;
      for (int i = 0; i < 100; i++) begin
         if (!acc_busy) break;
         if (mem_stb) ns++;
         if (acc_rdy) begin rc++; rat = ns; end
         if (mem_hold) nh++;
         @(negedge clk);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int ns, nh, rat, rc;
      rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; bus_grant = 1'b0;
      acc_req = 1'b0; acc_area = 2'd0; acc_rmw = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset value
      chk(cfg_rdata == 24'h1FFC00, "R1 reset word", int'(cfg_rdata), 'h1FFC00);
      chk(!acc_busy && !mem_stb && !bus_req && !bus_lock, "R1 idle outputs",
          int'({acc_busy, mem_stb, bus_req, bus_lock}), 0);

      // R7: no acceptance without ownership
      @(negedge clk); acc_req = 1'b1;
      repeat (3) @(negedge clk);
      chk(!acc_busy, "R7 no start without ownership", int'(acc_busy), 0);
      acc_req = 1'b0;

      // R2: reserved and read-only bits
      bus_grant = 1'b1;
      wr(24'hFFFFFF);
      chk(cfg_rdata == 24'hFFFC00, "R2 readback with ownership", int'(cfg_rdata), 'hFFFC00);
      bus_grant = 1'b0;
      @(negedge clk);
      chk(cfg_rdata == 24'hDFFC00, "R2 ownership bit follows grant", int'(cfg_rdata), 'hDFFC00);
      bus_grant = 1'b1;
      @(negedge clk);

      // R3 R4 R5 R6: vector table
      foreach (VEC[k]) begin
         logic [1:0] ar; logic [4:0] pc; int en, et;
         ar = VEC[k][13:12]; pc = VEC[k][11:7]; en = int'(VEC[k][6:2]); et = int'(VEC[k][1:0]);
         wr(word(1'b0, 1'b0, (ar < 2) ? pc : 5'd31,
                 (ar == 3) ? pc[2:0] : 3'd7, (ar == 2) ? pc[2:0] : 3'd7));
         run_acc(ar, 1'b0, ns, nh, rat, rc);
         chk(ns == en, "R3/R4 strobe cycles", ns, en);
         chk(nh == et, "R5 trailing cycles", nh, et);
         chk(rc == 1 && rat == en, "R6 ready position", rat, en);
      end

      // R7: back-to-back spacing with area-2 count 4: period 4+1+1
      wr(word(1'b0, 1'b0, 5'd31, 3'd7, 3'd4));
      @(negedge clk); acc_req = 1'b1; acc_area = 2'd2; acc_rmw = 1'b0;
      begin
         int first, second, prev, t;
         first = -1; second = -1; prev = 0; t = 0;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (mem_stb && !prev) begin
               if (first < 0) first = t; else if (second < 0) second = t;
            end
            prev = mem_stb; t++;
         end
         acc_req = 1'b0;
         chk(second - first == 6, "R7 back-to-back period", second - first, 6);
      end
      repeat (10) @(negedge clk);

      // R10: write and acceptance on the same edge
      wr(word(1'b0, 1'b0, 5'd31, 3'd7, 3'd2));
      @(negedge clk);
      acc_req = 1'b1; acc_area = 2'd2; cfg_we = 1'b1; cfg_wdata = word(1'b0, 1'b0, 5'd31, 3'd7, 3'd5);
      @(negedge clk);
      acc_req = 1'b0; cfg_we = 1'b0;
      ns = 0; nh = 0;
      for (int i = 0; i < 20; i++) begin
         if (!acc_busy) break;
         if (mem_stb) ns++;
         if (mem_hold) nh++;
         @(negedge clk);
      end
      chk(ns == 2 && nh == 0, "R10 old count used", ns, 2);
      run_acc(2'd2, 1'b0, ns, nh, rat, rc);
      chk(ns == 5 && nh == 1, "R10 new count used next", ns, 5);

      // R8 R9: hold bits x access type (0 none, 1 plain, 2 rmw)
      for (int h = 0; h < 4; h++) begin
         for (int ty = 0; ty < 3; ty++) begin
            bit fr, fl, er, el;
            fr = h[1]; fl = h[0];
            wr(word(fr, fl, 5'd31, 3'd7, 3'd3));
            er = fr || (ty != 0);
            el = fl || (ty == 2);
            if (ty != 0) begin
               @(negedge clk); acc_req = 1'b1; acc_area = 2'd2; acc_rmw = (ty == 2);
               @(negedge clk); acc_req = 1'b0;
            end else begin
               @(negedge clk);
            end
            chk(bus_req == er, "R8 bus request level", int'(bus_req), int'(er));
            chk(bus_lock == el, "R9 bus lock level", int'(bus_lock), int'(el));
            repeat (6) @(negedge clk);
            acc_rmw = 1'b0;
         end
      end

      // R8: pending request alone drives bus request
      wr(word(1'b0, 1'b0, 5'd31, 3'd7, 3'd7));
      bus_grant = 1'b0;
      @(negedge clk); @(negedge clk); acc_req = 1'b1;
      @(negedge clk);
      chk(bus_req && !acc_busy, "R8 pending request", int'(bus_req), 1);
      acc_req = 1'b0; bus_grant = 1'b1;
      @(negedge clk);

      summary();
   end
endmodule